// File: doc/BRIEF.md
# Serial Voltage-ID Command Receiver

This block is the receive side of a two-wire serial link that a processor uses to ask a voltage regulator for a new output level. It watches the clock and data lines with the system clock and finds start and stop conditions. After a start it collects an address byte (a 7-bit address and a direction bit) and pulls the data line low in the acknowledge slot only when the address is for this rail. It then collects one command byte, a power-state flag plus a 7-bit voltage code, and acknowledges it too.

The command is held back until the stop condition arrives. Only then does it reach the outputs, together with the decoded voltage: a step count in 12.5 mV units and an output-off flag. A one-cycle strobe marks each commit. If a new start or a reset cuts a transaction short, the outputs keep their old values. Reset loads a boot code that is set by parameter. A 3-bit strap picks which rail this instance answers for.

Top module: `vid_link_rx`

## Requirements
- R1: While reset is high and in the cycle after it, `vid_code_o` holds `BOOT_VID` (default 48), `pwr_state_o` holds `BOOT_PWR` (default 0), `step_cnt_o` holds the decoded boot step count (76), `out_off_o` is 0, and both `update_o` and `sda_drive_o` are 0.
- R2: An address byte is sent most significant bit first: address bits 6..0, then the direction bit, where 0 means write. The address matches when bits 6:4 are 110b, bits 2:0 equal `rail_sel_i`, and the direction bit is 0. On a match, `sda_drive_o` is high through the high phase of the ninth clock, and it only rises while the serial clock is low.
- R3: Address bit 3 has no effect on matching. A transaction with bit 3 at 1 is acknowledged and committed just like one with bit 3 at 0.
- R4: A wrong prefix, a wrong rail number or a read direction bit gets no acknowledge, either for the address or for the data byte, and no update follows at the stop.
- R5: After a matched address, the command byte is acknowledged in its ninth clock whatever its value.
- R6: The command byte is sent most significant bit first. Bit 7 is the power-state flag and bits 6:0 are the voltage code. These values appear on `pwr_state_o` and `vid_code_o` only after the stop condition, and `update_o` is high in the cycle they change.
- R7: Between the command acknowledge and the stop, the outputs keep their previous values.
- R8: If a start condition or a reset arrives before the stop, the pending command is dropped and no update follows.
- R9: For codes 0 to 123, `step_cnt_o` equals 124 minus the code (so the voltage is step count × 12.5 mV) and `out_off_o` is 0.
- R10: For codes 124 to 127, `out_off_o` is 1 and `step_cnt_o` is 0.
- R11: `update_o` is a single-cycle pulse, one per committed transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line as seen on the bus (asynchronous) |
| sda_drive_o | output | 1 | High pulls the data line low (acknowledge) |
| rail_sel_i | input | 3 | Strap compared with address bits 2:0 |
| vid_code_o | output | 7 | Committed voltage code |
| pwr_state_o | output | 1 | Committed power-state flag |
| step_cnt_o | output | 8 | Output level in 12.5 mV steps |
| out_off_o | output | 1 | Committed code is in the output-off range |
| update_o | output | 1 | One-cycle strobe when new values commit |

## Verification
Valid transactions use codes at both ends of the linear range (0 and 123), codes from the middle, and the first and last off codes. These show where the subtraction ends and the off range begins. Address bytes that differ from a valid one in a single field (the prefix, the rail number, the direction bit, or the reserved bit 3) show that each field is matched or ignored on its own. Transactions cut off by a repeated start or by a reset, along with checks taken between the acknowledge and the stop, show that a command takes effect only when a stop arrives.

// File: rtl/vid_rx_pkg.sv
package vid_rx_pkg;

  typedef enum logic [3:0] {
    FR_IDLE,
    FR_ADDR,
    FR_AACK_WAIT,
    FR_AACK_HOLD,
    FR_DATA,
    FR_DACK_WAIT,
    FR_DACK_HOLD,
    FR_HOLD,
    FR_IGNORE
  } frame_state_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/vid_line_sync.sv
module vid_line_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/vid_bus_events.sv
module vid_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/vid_frame_fsm.sv
module vid_frame_fsm
  import vid_rx_pkg::*;
#(
  parameter int unsigned        PREFIX_W = 3,
  parameter logic [PREFIX_W-1:0] PREFIX  = 3'b110,
  parameter int unsigned        SEL_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [SEL_W-1:0]  rail_sel,
  output logic              sda_drive,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_data
);

  localparam int unsigned CNT_W   = $clog2(BYTE_W + 1);
  localparam int unsigned ADDR_W  = BYTE_W - 1;
  localparam int unsigned RSV_BIT = ADDR_W - PREFIX_W - 1;

  frame_state_t      st;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] pend_data;
  logic              pend;
  logic [BYTE_W-1:0] next_byte;
  logic              last_bit;
  logic              addr_hit;

  assign next_byte = {shreg[BYTE_W-2:0], sda_s};
  assign last_bit  = (bit_cnt == CNT_W'(BYTE_W - 1));
  // next_byte[7:1] is the address; bit RSV_BIT+1 of the byte is the reserved bit
  assign addr_hit  = (next_byte[BYTE_W-1 -: PREFIX_W] == PREFIX) &&
                     (next_byte[SEL_W:1] == rail_sel) &&
                     (next_byte[0] == 1'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FR_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      pend_data <= '0;
      pend      <= 1'b0;
      sda_drive <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (start_evt) begin
        st        <= FR_ADDR;
        bit_cnt   <= '0;
        sda_drive <= 1'b0;
        pend      <= 1'b0;
      end else if (stop_evt) begin
        if (st == FR_HOLD && pend) begin
          cmd_valid <= 1'b1;
          cmd_data  <= pend_data;
        end
        st        <= FR_IDLE;
        sda_drive <= 1'b0;
        pend      <= 1'b0;
      end else begin
        unique case (st)
          FR_ADDR: if (scl_rise) begin
            shreg   <= next_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) st <= addr_hit ? FR_AACK_WAIT : FR_IGNORE;
          end
          FR_AACK_WAIT: if (scl_fall) begin
            sda_drive <= 1'b1;
            st        <= FR_AACK_HOLD;
          end
          FR_AACK_HOLD: if (scl_fall) begin
            sda_drive <= 1'b0;
            bit_cnt   <= '0;
            st        <= FR_DATA;
          end
          FR_DATA: if (scl_rise) begin
            shreg   <= next_byte;
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              pend_data <= next_byte;
              st        <= FR_DACK_WAIT;
            end
          end
          FR_DACK_WAIT: if (scl_fall) begin
            sda_drive <= 1'b1;
            st        <= FR_DACK_HOLD;
          end
          FR_DACK_HOLD: if (scl_fall) begin
            sda_drive <= 1'b0;
            pend      <= 1'b1;
            st        <= FR_HOLD;
          end
          default: st <= st;
        endcase
      end
    end
  end

  logic unused_rsv;
  assign unused_rsv = (RSV_BIT > 0);

endmodule

// File: rtl/vid_cmd_commit.sv
module vid_cmd_commit
  import vid_rx_pkg::*;
#(
  parameter int unsigned      VID_W     = 7,
  parameter int unsigned      STEP_W    = 8,
  parameter int unsigned      OFF_FIRST = 124,
  parameter logic [VID_W-1:0] BOOT_VID  = 7'd48,
  parameter logic             BOOT_PWR  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_data,
  output logic [VID_W-1:0]  vid_code,
  output logic              pwr_state,
  output logic [STEP_W-1:0] step_cnt,
  output logic              out_off,
  output logic              update
);

  function automatic logic is_off(input logic [VID_W-1:0] c);
    return int'(c) >= int'(OFF_FIRST);
  endfunction

  function automatic logic [STEP_W-1:0] to_steps(input logic [VID_W-1:0] c);
    if (is_off(c)) return '0;
    return STEP_W'(int'(OFF_FIRST) - int'(c));
  endfunction

  logic [VID_W-1:0] new_code;
  logic             new_pwr;

  assign new_code = cmd_data[VID_W-1:0];
  assign new_pwr  = cmd_data[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_code  <= BOOT_VID;
      pwr_state <= BOOT_PWR;
      step_cnt  <= to_steps(BOOT_VID);
      out_off   <= is_off(BOOT_VID);
      update    <= 1'b0;
    end else begin
      update <= cmd_valid;
      if (cmd_valid) begin
        vid_code  <= new_code;
        pwr_state <= new_pwr;
        step_cnt  <= to_steps(new_code);
        out_off   <= is_off(new_code);
      end
    end
  end

endmodule

// File: rtl/vid_link_rx.sv
module vid_link_rx
  import vid_rx_pkg::*;
#(
  parameter int unsigned      SYNC_STAGES = 2,
  parameter int unsigned      SEL_W       = 3,
  parameter int unsigned      VID_W       = 7,
  parameter int unsigned      STEP_W      = 8,
  parameter int unsigned      OFF_FIRST   = 124,
  parameter logic [2:0]       ADDR_PREFIX = 3'b110,
  parameter logic [VID_W-1:0] BOOT_VID    = 7'd48,
  parameter logic             BOOT_PWR    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_drive_o,
  input  logic [SEL_W-1:0]  rail_sel_i,
  output logic [VID_W-1:0]  vid_code_o,
  output logic              pwr_state_o,
  output logic [STEP_W-1:0] step_cnt_o,
  output logic              out_off_o,
  output logic              update_o
);

  logic [1:0]        lines_s;
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic              cmd_valid;
  logic [BYTE_W-1:0] cmd_data;

  vid_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({scl_i, sda_i}),
    .dout(lines_s)
  );

  vid_bus_events u_evt (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (lines_s[1]),
    .sda_s    (lines_s[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  vid_frame_fsm #(.PREFIX_W(3), .PREFIX(ADDR_PREFIX), .SEL_W(SEL_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_s    (lines_s[0]),
    .rail_sel (rail_sel_i),
    .sda_drive(sda_drive_o),
    .cmd_valid(cmd_valid),
    .cmd_data (cmd_data)
  );

  vid_cmd_commit #(
    .VID_W(VID_W), .STEP_W(STEP_W), .OFF_FIRST(OFF_FIRST),
    .BOOT_VID(BOOT_VID), .BOOT_PWR(BOOT_PWR)
  ) u_commit (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_data (cmd_data),
    .vid_code (vid_code_o),
    .pwr_state(pwr_state_o),
    .step_cnt (step_cnt_o),
    .out_off  (out_off_o),
    .update   (update_o)
  );

endmodule

// File: rtl/vid_link_rx_chk.sv
module vid_link_rx_chk #(
  parameter int unsigned VID_W     = 7,
  parameter int unsigned STEP_W    = 8,
  parameter int unsigned OFF_FIRST = 124
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_drive_o,
  input logic [VID_W-1:0]  vid_code_o,
  input logic              pwr_state_o,
  input logic [STEP_W-1:0] step_cnt_o,
  input logic              out_off_o,
  input logic              update_o
);

  a_r11_update_pulse: assert property (@(posedge clk) disable iff (rst)
    update_o |=> !update_o);

  a_r6_change_needs_update: assert property (@(posedge clk) disable iff (rst)
    ((vid_code_o != $past(vid_code_o)) || (pwr_state_o != $past(pwr_state_o))) |-> update_o);

  a_r9_step_sum: assert property (@(posedge clk) disable iff (rst)
    !out_off_o |-> (int'(step_cnt_o) + int'(vid_code_o) == int'(OFF_FIRST)));

  a_r10_off_zero_step: assert property (@(posedge clk) disable iff (rst)
    out_off_o |-> (step_cnt_o == '0) && (int'(vid_code_o) >= int'(OFF_FIRST)));

  a_r2_ack_on_low_clock: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_o) |-> !scl_i);

endmodule

bind vid_link_rx vid_link_rx_chk #(
  .VID_W(VID_W), .STEP_W(STEP_W), .OFF_FIRST(OFF_FIRST)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_i      (scl_i),
  .sda_drive_o(sda_drive_o),
  .vid_code_o (vid_code_o),
  .pwr_state_o(pwr_state_o),
  .step_cnt_o (step_cnt_o),
  .out_off_o  (out_off_o),
  .update_o   (update_o)
);

// File: tb/vid_link_rx_bench.sv
module vid_link_rx_bench;

  localparam logic [2:0] RAIL = 3'b011;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_drive;
  logic [6:0] vid_code;
  logic       pwr_state;
  logic [7:0] step_cnt;
  logic       out_off;
  logic       update;
  wire        sda_line = sda_m & ~sda_drive;

  always #4 clk = ~clk;

  vid_link_rx u_vid_link_rx (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_drive_o(sda_drive),
    .rail_sel_i (RAIL),
    .vid_code_o (vid_code),
    .pwr_state_o(pwr_state),
    .step_cnt_o (step_cnt),
    .out_off_o  (out_off),
    .update_o   (update)
  );

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct packed { logic psi; logic [6:0] code; } exp_t;
  exp_t       exp_q[$];
  logic [6:0] cur_code = 7'd48;
  logic       cur_psi  = 1'b0;

  function automatic int steps_of(input logic [6:0] c);
    return (c >= 7'd124) ? 0 : 124 - int'(c);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(4);
    scl_m = 1'b1; wt(4);
    sda_m = 1'b0; wt(4);
    scl_m = 1'b0; wt(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(4);
    scl_m = 1'b1; wt(4);
    sda_m = 1'b1; wt(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(4);
      scl_m = 1'b1; wt(8);
      scl_m = 1'b0; wt(4);
    end
    sda_m = 1'b1; wt(4);
    scl_m = 1'b1; wt(4);
    acked = ~sda_line;
    wt(4);
    scl_m = 1'b0; wt(4);
  endtask

  // Full write transaction; expected acknowledge and commit follow R2/R3/R4.
  task automatic txn(input logic [2:0] pfx, input logic rsv, input logic [2:0] rail,
                     input logic rw, input logic [7:0] data, input string req);
    logic match, a1, a2;
    match = (pfx == 3'b110) && (rail == RAIL) && !rw;
    bus_start();
    send_byte({pfx, rsv, rail, rw}, a1);
    send_byte(data, a2);
    check({req, " address ack"}, int'(a1), int'(match));
    check({req, " data ack"}, int'(a2), int'(match));
    // R7: nothing moves before stop
    check({"R7 ", req, " code before stop"}, int'(vid_code), int'(cur_code));
    if (match) exp_q.push_back({data[7], data[6:0]});
    bus_stop();
    wt(6);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && update) begin
      if (exp_q.size() == 0) begin
        check("R4/R8 unexpected update", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R6 code", int'(vid_code), int'(e.code));
        check("R6 power flag", int'(pwr_state), int'(e.psi));
        check("R9/R10 step", int'(step_cnt), steps_of(e.code));
        check("R10 off flag", int'(out_off), int'(e.code >= 7'd124));
        cur_code = e.code;
        cur_psi  = e.psi;
      end
    end
  end

  int upd_cnt = 0;
  always @(negedge clk) if (!rst && update) upd_cnt++;

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int u0;
    logic a1, a2;
    wt(5);
    check("R1 reset code", int'(vid_code), 48);
    check("R1 reset power flag", int'(pwr_state), 0);
    check("R1 reset step", int'(step_cnt), 76);
    check("R1 reset off", int'(out_off), 0);
    check("R1 reset update", int'(update), 0);
    rst = 1'b0;
    wt(1);
    check("R1 code after reset", int'(vid_code), 48);
    check("R1 drive after reset", int'(sda_drive), 0);

    txn(3'b110, 1'b0, RAIL, 1'b0, 8'h0C, "R2 R5 code 12");
    txn(3'b110, 1'b1, RAIL, 1'b0, {1'b1, 7'd108}, "R3 reserved bit set");
    txn(3'b110, 1'b0, RAIL, 1'b0, 8'h00, "R9 code 0");
    txn(3'b110, 1'b0, RAIL, 1'b0, {1'b1, 7'd123}, "R9 code 123");
    txn(3'b110, 1'b0, RAIL, 1'b0, {1'b0, 7'd124}, "R10 code 124");
    txn(3'b110, 1'b1, RAIL, 1'b0, {1'b1, 7'd127}, "R10 code 127");
    txn(3'b110, 1'b0, RAIL, 1'b0, {1'b0, 7'd60}, "R5 code 60");

    u0 = upd_cnt;
    txn(3'b101, 1'b0, RAIL, 1'b0, 8'h20, "R4 bad prefix");
    txn(3'b110, 1'b0, 3'b010, 1'b0, 8'h20, "R4 bad rail");
    txn(3'b110, 1'b0, RAIL, 1'b1, 8'h20, "R4 read bit");
    check("R4 no update on mismatch", upd_cnt - u0, 0);
    check("R4 code kept", int'(vid_code), 60);

    // R8: repeated start before stop drops the command
    u0 = upd_cnt;
    bus_start();
    send_byte({3'b110, 1'b0, RAIL, 1'b0}, a1);
    send_byte(8'h30, a2);
    check("R8 abort address ack", int'(a1), 1);
    bus_start();
    bus_stop();
    wt(6);
    check("R8 no update after restart", upd_cnt - u0, 0);
    check("R8 code kept", int'(vid_code), 60);

    // R8: reset before stop drops the command and restores boot values
    bus_start();
    send_byte({3'b110, 1'b0, RAIL, 1'b0}, a1);
    send_byte(8'h40, a2);
    rst = 1'b1; wt(3);
    rst = 1'b0;
    cur_code = 7'd48; cur_psi = 1'b0;
    u0 = upd_cnt;
    bus_stop();
    wt(6);
    check("R8 no update after reset", upd_cnt - u0, 0);
    check("R1 boot code after reset", int'(vid_code), 48);
    check("R1 boot step after reset", int'(step_cnt), 76);

    // recovery and R11 strobe count
    u0 = upd_cnt;
    txn(3'b110, 1'b0, RAIL, 1'b0, {1'b1, 7'd20}, "R6 recovery");
    check("R11 one strobe per commit", upd_cnt - u0, 1);
    check("R6 scoreboard drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule